// File: doc/BRIEF.md
# Breakpoint Halt and Spin Controller

This unit sits between the instruction decoder of a small 8-bit processor and its debug controller. It watches every decoded opcode for the breakpoint opcode 0x00, which is the value of a fully programmed flash byte. When the opcode appears, the unit chooses one of three outcomes from two configuration inputs: treat it as a no-operation, halt the processor in debug mode, or spin on the opcode.

In spin mode the processor keeps re-executing the breakpoint opcode instead of stopping. Interrupt and DMA requests can still take it away to be serviced. The unit saves the address of the spinning opcode. When execution returns to that address, it either resumes spinning or, if spin mode has been switched off in the meantime, halts and enters debug mode by itself. A breakpoint opcode met at any other address while the processor is away servicing a request causes a real halt. Debug mode can also be forced by a host request, and it ends only on an explicit resume.

Top module: `brk_ctl_unit`

## Requirements
- R1: Only a decode strobe carrying opcode 0x00 counts as a breakpoint. Any other opcode leaves every output unchanged.
- R2: With breakpoints disabled (`brk_en`=0), a breakpoint decode pulses `as_nop` high for exactly the next cycle. No other output changes.
- R3: With breakpoints enabled and spin off, a breakpoint decode sets `cpu_stall` and `dbg_mode` in the next cycle. Both stay set until a resume.
- R4: With breakpoints enabled and spin on, a breakpoint decode sets `spin_idle` and saves the opcode's address in the next cycle. `cpu_stall` stays low.
- R5: While spinning, an interrupt or DMA request clears `spin_idle` in the next cycle, and `cpu_stall` stays low. The unit is then pending on the saved address.
- R6: `cmd_ok` is high only while `cpu_stall` and `dbg_mode` are both high. It is never high while spinning.
- R7: While pending, a breakpoint decode at the saved address returns the unit to spinning if spin is still on. If spin is off, it halts the processor in debug mode.
- R8: While pending, a breakpoint decode at any other address, with breakpoints enabled, halts the processor in debug mode.
- R9: While spinning with spin switched off, the next breakpoint decode at the saved address halts the processor in debug mode.
- R10: `dbg_req` halts the processor in debug mode from any state. Only `resume` clears debug mode and the stall.
- R11: Reset asynchronously clears all status outputs, whatever the configuration inputs are. The unit ignores decodes until the second clock edge after `rst_n` rises.
- R12: When `dbg_req` and `resume` are high in the same cycle, `dbg_req` wins and the processor stays halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode strobe |
| dec_opcode | input | 8 | Opcode being decoded |
| dec_pc | input | PC_W | Address of the decoded opcode |
| brk_en | input | 1 | Breakpoints enabled (configuration) |
| spin_en | input | 1 | Spin on breakpoint instead of halting (configuration) |
| irq_req | input | 1 | Interrupt request to be serviced |
| dma_req | input | 1 | DMA request to be serviced |
| dbg_req | input | 1 | Host request to enter debug mode |
| resume | input | 1 | Leave debug mode and run |
| cpu_stall | output | 1 | Processor halted |
| spin_idle | output | 1 | Processor spinning on the breakpoint opcode |
| dbg_mode | output | 1 | Debug mode flag |
| as_nop | output | 1 | Previous breakpoint decode is to execute as a no-operation |
| cmd_ok | output | 1 | Debug commands permitted |

## Verification
The hardest situation to reach is the deferred stop. The processor must be spinning, leave for an interrupt or DMA request, and have spin mode cleared while it is away. It must then come back to the saved address, which must also be told apart from a breakpoint met at a different address inside the service routine. The vector table drives this as a sequence of decodes with chosen addresses and timed requests: it enters spin, raises a request, and decodes an unrelated opcode. It then returns to the saved address once with spin on and once with spin off. A later run breaks at a foreign address while pending.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam logic [7:0] BRK_OPCODE = 8'h00;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SPIN = 2'd1,
    ST_AWAY = 2'd2,
    ST_HALT = 2'd3
  } brk_state_t;

endpackage

// File: rtl/brk_rst_sync.sv
module brk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/brk_match.sv
module brk_match #(
  parameter int OP_W = 8,
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            dec_valid,
  input  logic [OP_W-1:0] dec_opcode,
  input  logic [PC_W-1:0] dec_pc,
  input  logic            save_en,
  output logic            brk_hit,
  output logic            pc_match
);

  import brk_pkg::*;

  logic [PC_W-1:0] saved_pc_q;
  logic [PC_W-1:0] saved_pc_d;

  assign brk_hit  = dec_valid && (dec_opcode == OP_W'(BRK_OPCODE));
  assign pc_match = (dec_pc == saved_pc_q);

  always_comb begin
    saved_pc_d = saved_pc_q;
    if (save_en) saved_pc_d = dec_pc;
  end

  always_ff @(posedge clk) begin
    if (save_en) saved_pc_q <= saved_pc_d;
  end

endmodule

// File: rtl/brk_fsm.sv
module brk_fsm (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic brk_hit,
  input  logic pc_match,
  input  logic brk_en,
  input  logic spin_en,
  input  logic irq_req,
  input  logic dma_req,
  input  logic dbg_req,
  input  logic resume,
  output logic save_en,
  output logic cpu_stall,
  output logic spin_idle,
  output logic dbg_mode,
  output logic as_nop
);

  import brk_pkg::*;

  brk_state_t st_q, st_d;
  logic       dbg_q, dbg_d;
  logic       nop_q, nop_d;

  always_comb begin
    st_d    = st_q;
    save_en = 1'b0;
    nop_d   = 1'b0;
    if (dbg_req) begin
      st_d = ST_HALT;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (brk_hit) begin
            if (!brk_en)      nop_d = 1'b1;
            else if (spin_en) begin
              st_d    = ST_SPIN;
              save_en = 1'b1;
            end else          st_d = ST_HALT;
          end
        end
        ST_SPIN: begin
          if (irq_req || dma_req) begin
            st_d = ST_AWAY;
          end else if (brk_hit && pc_match) begin
            if (!brk_en) begin
              st_d  = ST_RUN;
              nop_d = 1'b1;
            end else if (!spin_en) st_d = ST_HALT;
          end
        end
        ST_AWAY: begin
          if (brk_hit) begin
            if (!brk_en) begin
              nop_d = 1'b1;
              if (pc_match) st_d = ST_RUN;
            end else if (pc_match && spin_en) st_d = ST_SPIN;
            else                               st_d = ST_HALT;
          end
        end
        ST_HALT: begin
          if (resume) st_d = ST_RUN;
        end
        default: st_d = ST_RUN;
      endcase
    end
    dbg_d = (st_d == ST_HALT);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= ST_RUN;
      dbg_q <= 1'b0;
      nop_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dbg_q <= dbg_d;
      nop_q <= nop_d;
    end
  end

  assign cpu_stall = (st_q == ST_HALT);
  assign spin_idle = (st_q == ST_SPIN);
  assign dbg_mode  = dbg_q;
  assign as_nop    = nop_q;

  AST_STALL_IMPLIES_DBG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_stall |-> dbg_mode); // R3
  AST_SPIN_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spin_idle |-> !cpu_stall); // R4
  AST_NOP_NEEDS_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_hit && brk_en && !dbg_req |=> !as_nop); // R2
  AST_REQ_LEAVES_SPIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spin_idle && (irq_req || dma_req) && !dbg_req |=> !spin_idle && !cpu_stall); // R5
  AST_DBG_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_mode && !resume |=> dbg_mode); // R10
  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_req |=> cpu_stall && dbg_mode); // R12

endmodule

// File: rtl/brk_ctl_unit.sv
module brk_ctl_unit #(
  parameter int PC_W = 16,
  parameter int OP_W = 8,
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [OP_W-1:0] dec_opcode,
  input  logic [PC_W-1:0] dec_pc,
  input  logic            brk_en,
  input  logic            spin_en,
  input  logic            irq_req,
  input  logic            dma_req,
  input  logic            dbg_req,
  input  logic            resume,
  output logic            cpu_stall,
  output logic            spin_idle,
  output logic            dbg_mode,
  output logic            as_nop,
  output logic            cmd_ok
);

  logic rst_sync_n;
  logic brk_hit;
  logic pc_match;
  logic save_en;

  brk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  brk_match #(.OP_W(OP_W), .PC_W(PC_W)) u_match (
    .clk        (clk),
    .dec_valid  (dec_valid),
    .dec_opcode (dec_opcode),
    .dec_pc     (dec_pc),
    .save_en    (save_en),
    .brk_hit    (brk_hit),
    .pc_match   (pc_match)
  );

  brk_fsm u_fsm (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .brk_hit    (brk_hit),
    .pc_match   (pc_match),
    .brk_en     (brk_en),
    .spin_en    (spin_en),
    .irq_req    (irq_req),
    .dma_req    (dma_req),
    .dbg_req    (dbg_req),
    .resume     (resume),
    .save_en    (save_en),
    .cpu_stall  (cpu_stall),
    .spin_idle  (spin_idle),
    .dbg_mode   (dbg_mode),
    .as_nop     (as_nop)
  );

  assign cmd_ok = cpu_stall && dbg_mode;

  AST_NO_CMD_WHILE_SPIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spin_idle |-> !cmd_ok); // R6
  AST_OTHER_OPCODE_INERT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_stall && dec_valid && (dec_opcode != '0) && !resume |=> cpu_stall); // R1

endmodule

// File: tb/brk_ctl_unit_test.sv
module brk_ctl_unit_test;

  localparam int PC_W = 16;
  localparam int NV   = 25;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            dec_valid;
  logic [7:0]      dec_opcode;
  logic [PC_W-1:0] dec_pc;
  logic            brk_en, spin_en, irq_req, dma_req, dbg_req, resume;
  logic            cpu_stall, spin_idle, dbg_mode, as_nop, cmd_ok;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  brk_ctl_unit #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_opcode(dec_opcode),
    .dec_pc(dec_pc), .brk_en(brk_en), .spin_en(spin_en), .irq_req(irq_req),
    .dma_req(dma_req), .dbg_req(dbg_req), .resume(resume),
    .cpu_stall(cpu_stall), .spin_idle(spin_idle), .dbg_mode(dbg_mode),
    .as_nop(as_nop), .cmd_ok(cmd_ok)
  );

  // {valid, opcode, pc, {en,spin,irq,dma,dreq,resume}, {stall,idle,dbg,nop,cmd}}
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 6'b000000, 5'b00000},  // 0  quiet
    {1'b1, 8'h05, 8'h10, 6'b100000, 5'b00000},  // 1  R1 other opcode
    {1'b1, 8'h00, 8'h11, 6'b000000, 5'b00010},  // 2  R2 disabled -> nop
    {1'b0, 8'h00, 8'h00, 6'b000000, 5'b00000},  // 3  R2 nop one cycle
    {1'b1, 8'h00, 8'h12, 6'b100000, 5'b10101},  // 4  R3 halt
    {1'b0, 8'h00, 8'h00, 6'b100000, 5'b10101},  // 5  R3 held, R6 cmd
    {1'b0, 8'h00, 8'h00, 6'b100001, 5'b00000},  // 6  R10 resume
    {1'b1, 8'h00, 8'h20, 6'b110000, 5'b01000},  // 7  R4 spin
    {1'b1, 8'h00, 8'h20, 6'b110000, 5'b01000},  // 8  R4 keeps spinning
    {1'b0, 8'h00, 8'h00, 6'b111000, 5'b00000},  // 9  R5 irq
    {1'b1, 8'h33, 8'h40, 6'b110000, 5'b00000},  // 10 R1 isr opcode
    {1'b1, 8'h00, 8'h20, 6'b110000, 5'b01000},  // 11 R7 back, spin on
    {1'b0, 8'h00, 8'h00, 6'b110100, 5'b00000},  // 12 R5 dma
    {1'b1, 8'h00, 8'h20, 6'b100000, 5'b10101},  // 13 R7 back, spin off
    {1'b0, 8'h00, 8'h00, 6'b100001, 5'b00000},  // 14 resume
    {1'b1, 8'h00, 8'h30, 6'b110000, 5'b01000},  // 15 spin
    {1'b1, 8'h00, 8'h30, 6'b100000, 5'b10101},  // 16 R9 spin cleared
    {1'b0, 8'h00, 8'h00, 6'b100001, 5'b00000},  // 17 resume
    {1'b1, 8'h00, 8'h50, 6'b110000, 5'b01000},  // 18 spin
    {1'b0, 8'h00, 8'h00, 6'b111000, 5'b00000},  // 19 irq
    {1'b1, 8'h00, 8'h60, 6'b110000, 5'b10101},  // 20 R8 foreign address
    {1'b0, 8'h00, 8'h00, 6'b000001, 5'b00000},  // 21 resume
    {1'b0, 8'h00, 8'h00, 6'b000010, 5'b10101},  // 22 R10 host request
    {1'b0, 8'h00, 8'h00, 6'b000011, 5'b10101},  // 23 R12 both
    {1'b0, 8'h00, 8'h00, 6'b000001, 5'b00000}   // 24 resume
  };

  task automatic drive(input logic [22:0] s);
    dec_valid  = s[22];
    dec_opcode = s[21:14];
    dec_pc     = {8'h00, s[13:6]};
    {brk_en, spin_en, irq_req, dma_req, dbg_req, resume} = s[5:0];
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {cpu_stall, spin_idle, dbg_mode, as_nop, cmd_ok};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {stall,idle,dbg,nop,cmd} actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(23'h0);
    brk_en = 1'b1;
    spin_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset state", 5'b00000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][27:5]);
      @(posedge clk);
      #1;
      check($sformatf("vector %0d", i), VEC[i][4:0]);
    end

    // R11: asynchronous clear while spinning
    @(negedge clk);
    drive({1'b1, 8'h00, 8'h70, 6'b110000});
    @(posedge clk);
    #1;
    check("R4 spin before reset", 5'b01000);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R11 async clear", 5'b00000);

    // R11: decodes ignored until second edge after release
    @(negedge clk);
    drive({1'b1, 8'h00, 8'h71, 6'b100000});
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R11 first edge ignored", 5'b00000);
    @(posedge clk);
    #1;
    check("R11 second edge ignored", 5'b00000);
    @(posedge clk);
    #1;
    check("R11 active on third edge, R3 halt", 5'b10101);

    // R1: non-breakpoint opcode while halted keeps halt
    @(negedge clk);
    drive({1'b1, 8'hFF, 8'h72, 6'b100000});
    @(posedge clk);
    #1;
    check("R1 opcode FF inert", 5'b10101);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule